// File: doc/BRIEF.md
# Handshake Stall Recovery Supervisor

This block sits beside a single manager-to-subordinate AXI link and only observes it. It watches the five channels (write address, write data, write response, read address, read data). It tracks how many writes and reads are in flight. It also times how long each channel has held VALID high while READY stays low. The protocol has no way to abort a transfer that is never accepted, so the only remedy the supervisor offers is a reset request. It chooses which side to reset based on which channel stalled and on what other traffic is still owed.

An address channel that stalls while nothing else is outstanding leads to a reset of the subordinate only. In that case the manager keeps its pending request and presents it again once the subordinate returns. If other transactions are still in flight, the reset is deferred until they drain. If they do not drain within a second limit, the supervisor escalates to resetting both sides. A stall on any data or response channel always resets both sides, because the manager holds a transaction that can never complete. A separate output flags any channel that drops VALID before its transfer was accepted.

Top module: `axi_hang_supervisor`

## Requirements
- R1: When a channel had VALID high and READY low on one clock edge and VALID is low at the next edge, the matching bit of `proto_err` is high for exactly one cycle after that edge. Bit order: 0 write address, 1 write data, 2 write response, 3 read address, 4 read data.
- R2: A READY that arrives before the stall limit is reached completes the transfer with no reset request and no protocol error.
- R3: VALID held without READY for `stall_limit` consecutive edges declares a stall. The reset request then goes high on the next edge, that is `stall_limit`+1 edges after VALID was first sampled.
- R4: A stall on the write address or read address channel while no write and no read is outstanding raises `slave_rst_req` only, with `master_rst_req` low.
- R5: A stall on an address channel while writes or reads are outstanding raises no request at first. Once both outstanding counts reach zero, `slave_rst_req` alone rises one edge later.
- R6: If a deferred reset does not drain within `drain_limit` further cycles, both `slave_rst_req` and `master_rst_req` are raised.
- R7: A stall on the write data, write response or read data channel raises both requests at once.
- R8: The write count rises on a write address handshake and falls on a write response handshake. The read count rises on a read address handshake and falls only on a read data handshake with `r_last` high. A read data beat without `r_last` leaves the read outstanding.
- R9: Reset requests stay high for exactly `HOLD_CYCLES` cycles. After that, all counts and timers are cleared and the supervisor is idle again.
- R10: `status_valid`, `status_chan` (the channel code, using the R1 numbering) and `status_action` (1 subordinate now, 2 subordinate after drain, 3 both sides) record the latest decision. They hold after the request ends and are cleared only by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address VALID |
| aw_ready | input | 1 | Write address READY |
| w_valid | input | 1 | Write data VALID |
| w_ready | input | 1 | Write data READY |
| b_valid | input | 1 | Write response VALID |
| b_ready | input | 1 | Write response READY |
| ar_valid | input | 1 | Read address VALID |
| ar_ready | input | 1 | Read address READY |
| r_valid | input | 1 | Read data VALID |
| r_ready | input | 1 | Read data READY |
| r_last | input | 1 | Last read data beat |
| stall_limit | input | TIMER_W | Cycles of unanswered VALID that count as a stall |
| drain_limit | input | TIMER_W | Cycles a deferred reset waits for drain |
| slave_rst_req | output | 1 | Subordinate reset request |
| master_rst_req | output | 1 | Manager reset request |
| proto_err | output | 5 | Per-channel early VALID drop pulse |
| status_valid | output | 1 | A decision has been recorded |
| status_chan | output | 3 | Channel of the recorded stall |
| status_action | output | 2 | Recorded action code |

## Verification
The deferred path is the hardest to reach from the ports. It needs an address stall that begins while earlier traffic is still owed. The outcome then depends on whether that traffic finishes inside the drain window. The stimulus completes an address handshake (and, for writes, the data handshake) but holds back the response. It then holds a new address VALID without READY and delivers the owed response in the middle of the window. One run uses a write response. Another uses a read burst whose non-final beat must not count as completion. A third run never drains, so that escalation is exercised.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int NCH = 5;

    typedef enum logic [2:0] {
        CH_AW = 3'd0,
        CH_W  = 3'd1,
        CH_B  = 3'd2,
        CH_AR = 3'd3,
        CH_R  = 3'd4
    } chan_e;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_SLAVE   = 2'd1,
        ACT_DRAINED = 2'd2,
        ACT_BOTH    = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEFER = 2'd1,
        ST_HOLD  = 2'd2
    } state_e;
endpackage

// File: rtl/hs_stall_timer.sv
module hs_stall_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          valid,
    input  logic          ready,
    input  logic [TW-1:0] limit,
    output logic          fire,
    output logic          proto_err
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
        logic          err;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            s_d.pend = valid && !ready;
            s_d.err  = s_q.pend && !valid;
            if (valid && !ready) begin
                if (s_q.cnt < limit) s_d.cnt = s_q.cnt + 1'b1;
            end else begin
                s_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fire      = (s_q.cnt >= limit) && (s_q.cnt != '0);
    assign proto_err = s_q.err;

    // R3: a stall can only be reported after an unanswered VALID
    p_fire_follows_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(valid && !ready));
endmodule

// File: rtl/hs_txn_tracker.sv
module hs_txn_tracker #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          aw_hs,
    input  logic          b_hs,
    input  logic          ar_hs,
    input  logic          r_last_hs,
    output logic [CW-1:0] wr_out,
    output logic [CW-1:0] rd_out
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] wr;
        logic [CW-1:0] rd;
    } trk_s;

    trk_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            case ({aw_hs, b_hs})
                2'b10:   if (s_q.wr != CMAX) s_d.wr = s_q.wr + 1'b1;
                2'b01:   if (s_q.wr != '0)   s_d.wr = s_q.wr - 1'b1;
                default: s_d.wr = s_q.wr;
            endcase
            case ({ar_hs, r_last_hs})
                2'b10:   if (s_q.rd != CMAX) s_d.rd = s_q.rd + 1'b1;
                2'b01:   if (s_q.rd != '0)   s_d.rd = s_q.rd - 1'b1;
                default: s_d.rd = s_q.rd;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_out = s_q.wr;
    assign rd_out = s_q.rd;

    // R8: the read count moves only on a read address or a final read beat
    p_rd_holds_without_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_hs && !r_last_hs && !clr) |=> $stable(rd_out));
endmodule

// File: rtl/hs_recovery_fsm.sv
module hs_recovery_fsm
    import hs_pkg::*;
#(
    parameter int TW          = 16,
    parameter int HOLD_CYCLES = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] fire,
    input  logic           wr_busy,
    input  logic           rd_busy,
    input  logic [TW-1:0]  drain_limit,
    output logic           slave_req,
    output logic           master_req,
    output logic           clr_all,
    output logic           status_valid,
    output logic [2:0]     status_chan,
    output logic [1:0]     status_action
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

    typedef struct packed {
        state_e        st;
        act_e          act;
        chan_e         ch;
        logic [HW-1:0] hold;
        logic [TW-1:0] drain;
        logic          sv;
        chan_e         sch;
        act_e          sact;
    } fsm_s;

    fsm_s  s_d, s_q;
    chan_e pick;
    logic  have;
    logic  quiet;

    always_comb begin
        pick = CH_AW;
        have = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (fire[i]) begin
                pick = chan_e'(3'(i));
                have = 1'b1;
            end
        end
    end

    assign quiet = !wr_busy && !rd_busy;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (have) begin
                    s_d.ch = pick;
                    if (pick == CH_AW || pick == CH_AR) begin
                        if (quiet) begin
                            s_d.st   = ST_HOLD;
                            s_d.act  = ACT_SLAVE;
                            s_d.sv   = 1'b1;
                            s_d.sch  = pick;
                            s_d.sact = ACT_SLAVE;
                        end else begin
                            s_d.st    = ST_DEFER;
                            s_d.drain = '0;
                        end
                    end else begin
                        s_d.st   = ST_HOLD;
                        s_d.act  = ACT_BOTH;
                        s_d.sv   = 1'b1;
                        s_d.sch  = pick;
                        s_d.sact = ACT_BOTH;
                    end
                end
            end
            ST_DEFER: begin
                if (quiet) begin
                    s_d.st   = ST_HOLD;
                    s_d.act  = ACT_DRAINED;
                    s_d.sv   = 1'b1;
                    s_d.sch  = s_q.ch;
                    s_d.sact = ACT_DRAINED;
                end else if (s_q.drain >= drain_limit) begin
                    s_d.st   = ST_HOLD;
                    s_d.act  = ACT_BOTH;
                    s_d.sv   = 1'b1;
                    s_d.sch  = s_q.ch;
                    s_d.sact = ACT_BOTH;
                end else begin
                    s_d.drain = s_q.drain + 1'b1;
                end
            end
            ST_HOLD: begin
                if (s_q.hold == HOLD_LAST) begin
                    s_d.st    = ST_IDLE;
                    s_d.act   = ACT_NONE;
                    s_d.hold  = '0;
                    s_d.drain = '0;
                end else begin
                    s_d.hold = s_q.hold + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.act  <= ACT_NONE;
            s_q.ch   <= CH_AW;
            s_q.sch  <= CH_AW;
            s_q.sact <= ACT_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign slave_req     = (s_q.st == ST_HOLD);
    assign master_req    = (s_q.st == ST_HOLD) && (s_q.act == ACT_BOTH);
    assign clr_all       = (s_q.st == ST_HOLD);
    assign status_valid  = s_q.sv;
    assign status_chan   = s_q.sch;
    assign status_action = s_q.sact;

    // R4: isolated address stall resets the subordinate only
    p_isolated_slave_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && fire[0] && quiet) |=> (slave_req && !master_req));

    // R5: no request while waiting for outstanding traffic inside the window
    p_defer_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DEFER && !quiet && s_q.drain < drain_limit) |=> !slave_req);

    // R7: a write data stall resets both sides
    p_w_stall_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && fire[1:0] == 2'b10) |=> master_req);

    // R10: the recorded status never clears outside reset
    p_status_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |=> status_valid);
endmodule

// File: rtl/axi_hang_supervisor.sv
module axi_hang_supervisor
    import hs_pkg::*;
#(
    parameter int TIMER_W     = 16,
    parameter int CNT_W       = 8,
    parameter int HOLD_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               aw_valid,
    input  logic               aw_ready,
    input  logic               w_valid,
    input  logic               w_ready,
    input  logic               b_valid,
    input  logic               b_ready,
    input  logic               ar_valid,
    input  logic               ar_ready,
    input  logic               r_valid,
    input  logic               r_ready,
    input  logic               r_last,
    input  logic [TIMER_W-1:0] stall_limit,
    input  logic [TIMER_W-1:0] drain_limit,
    output logic               slave_rst_req,
    output logic               master_rst_req,
    output logic [4:0]         proto_err,
    output logic               status_valid,
    output logic [2:0]         status_chan,
    output logic [1:0]         status_action
);
    logic [NCH-1:0] vld, rdy, fire, perr;
    logic [CNT_W-1:0] wr_out, rd_out;
    logic clr_all;

    assign vld = {r_valid, ar_valid, b_valid, w_valid, aw_valid};
    assign rdy = {r_ready, ar_ready, b_ready, w_ready, aw_ready};

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        hs_stall_timer #(.TW(TIMER_W)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr_all),
            .valid     (vld[c]),
            .ready     (rdy[c]),
            .limit     (stall_limit),
            .fire      (fire[c]),
            .proto_err (perr[c])
        );
    end

    hs_txn_tracker #(.CW(CNT_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_all),
        .aw_hs     (aw_valid && aw_ready),
        .b_hs      (b_valid && b_ready),
        .ar_hs     (ar_valid && ar_ready),
        .r_last_hs (r_valid && r_ready && r_last),
        .wr_out    (wr_out),
        .rd_out    (rd_out)
    );

    hs_recovery_fsm #(.TW(TIMER_W), .HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire          (fire),
        .wr_busy       (wr_out != '0),
        .rd_busy       (rd_out != '0),
        .drain_limit   (drain_limit),
        .slave_req     (slave_rst_req),
        .master_req    (master_rst_req),
        .clr_all       (clr_all),
        .status_valid  (status_valid),
        .status_chan   (status_chan),
        .status_action (status_action)
    );

    assign proto_err = perr;
endmodule

// File: tb/test_axi_hang_supervisor.sv
module test_axi_hang_supervisor;
    localparam int TW = 16;
    localparam int SL = 8;
    localparam int DL = 10;
    localparam int HC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] vld = '0;
    logic [4:0] rdy = '0;
    logic lst = 1'b0;
    logic slave_rst_req, master_rst_req, status_valid;
    logic [4:0] proto_err;
    logic [2:0] status_chan;
    logic [1:0] status_action;
    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    axi_hang_supervisor #(.TIMER_W(TW), .CNT_W(8), .HOLD_CYCLES(HC)) i_axi_hang_supervisor (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(vld[0]), .aw_ready(rdy[0]),
        .w_valid(vld[1]),  .w_ready(rdy[1]),
        .b_valid(vld[2]),  .b_ready(rdy[2]),
        .ar_valid(vld[3]), .ar_ready(rdy[3]),
        .r_valid(vld[4]),  .r_ready(rdy[4]), .r_last(lst),
        .stall_limit(TW'(SL)), .drain_limit(TW'(DL)),
        .slave_rst_req(slave_rst_req), .master_rst_req(master_rst_req),
        .proto_err(proto_err), .status_valid(status_valid),
        .status_chan(status_chan), .status_action(status_action)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vld = '0; rdy = '0; lst = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic handshake(input int ch, input logic last);
        vld[ch] = 1'b1; rdy[ch] = 1'b1; lst = last;
        @(negedge clk);
        vld[ch] = 1'b0; rdy[ch] = 1'b0; lst = 1'b0;
    endtask

    task automatic wait_req(input int maxc, output int cyc);
        cyc = 0;
        while (!(slave_rst_req || master_rst_req) && cyc < maxc) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset_state();
        chk("R9 reset slave req", int'(slave_rst_req), 0);
        chk("R9 reset master req", int'(master_rst_req), 0);
        chk("R10 reset status_valid", int'(status_valid), 0);
        chk("R1 reset proto_err", int'(proto_err), 0);
    endtask

    task automatic t_late_ready();
        int seen = 0;
        vld[3] = 1'b1;
        repeat (5) @(negedge clk);
        rdy[3] = 1'b1;
        @(negedge clk);
        vld[3] = 1'b0; rdy[3] = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (slave_rst_req || master_rst_req || proto_err != 0) seen++;
        end
        chk("R2 late ready raises nothing", seen, 0);
        do_reset();
    endtask

    task automatic t_aw_alone();
        int cyc, n;
        vld[0] = 1'b1;
        wait_req(40, cyc);
        chk("R3 stall request latency", cyc, SL + 1);
        chk("R4 slave req", int'(slave_rst_req), 1);
        chk("R4 master req low", int'(master_rst_req), 0);
        chk("R10 status chan AW", int'(status_chan), 0);
        chk("R10 status action slave", int'(status_action), 1);
        n = 0;
        while (slave_rst_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R9 hold length", n, HC);
        chk("R9 request released", int'(slave_rst_req), 0);
        chk("R10 status sticky", int'(status_valid), 1);
        do_reset();
    endtask

    task automatic t_aw_drain();
        int seen = 0;
        handshake(0, 1'b0);
        handshake(1, 1'b1);
        vld[0] = 1'b1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (slave_rst_req || master_rst_req) seen++;
        end
        chk("R5 no request while write owed", seen, 0);
        handshake(2, 1'b0);
        @(negedge clk);
        chk("R5 slave req after drain", int'(slave_rst_req), 1);
        chk("R5 master req low after drain", int'(master_rst_req), 0);
        chk("R10 action drained", int'(status_action), 2);
        do_reset();
    endtask

    task automatic t_aw_escalate();
        int cyc;
        handshake(3, 1'b0);
        vld[0] = 1'b1;
        wait_req(60, cyc);
        chk("R6 escalation latency", cyc, SL + 2 + DL);
        chk("R6 master req", int'(master_rst_req), 1);
        chk("R6 slave req", int'(slave_rst_req), 1);
        chk("R10 action both", int'(status_action), 3);
        chk("R10 chan AW", int'(status_chan), 0);
        do_reset();
    endtask

    task automatic t_ar_rlast();
        int seen = 0;
        handshake(3, 1'b0);
        handshake(4, 1'b0);
        vld[3] = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (slave_rst_req || master_rst_req) seen++;
        end
        chk("R8 non-last beat keeps read owed", seen, 0);
        handshake(4, 1'b1);
        @(negedge clk);
        chk("R8 last beat drains read", int'(slave_rst_req), 1);
        chk("R8 master low", int'(master_rst_req), 0);
        chk("R10 chan AR", int'(status_chan), 3);
        do_reset();
    endtask

    task automatic t_w_stall();
        int cyc;
        handshake(0, 1'b0);
        vld[1] = 1'b1;
        wait_req(40, cyc);
        chk("R7 W stall latency", cyc, SL + 1);
        chk("R7 W stall master req", int'(master_rst_req), 1);
        chk("R7 W stall slave req", int'(slave_rst_req), 1);
        chk("R10 chan W", int'(status_chan), 1);
        do_reset();
    endtask

    task automatic t_b_stall();
        int cyc;
        vld[2] = 1'b1;
        wait_req(40, cyc);
        chk("R7 B stall master req", int'(master_rst_req), 1);
        chk("R10 chan B", int'(status_chan), 2);
        do_reset();
    endtask

    task automatic t_proto();
        vld[3] = 1'b1;
        repeat (3) @(negedge clk);
        vld[3] = 1'b0;
        @(negedge clk);
        chk("R1 early drop flagged", int'(proto_err), 5'b01000);
        @(negedge clk);
        chk("R1 flag lasts one cycle", int'(proto_err), 0);
        handshake(1, 1'b1);
        @(negedge clk);
        chk("R1 clean handshake not flagged", int'(proto_err), 0);
        do_reset();
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_late_ready();
        t_aw_alone();
        t_aw_drain();
        t_aw_escalate();
        t_ar_rlast();
        t_w_stall();
        t_b_stall();
        t_proto();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            vectors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule